// File: doc/BRIEF.md
# Packed SIMD Floating-Point Minimum/Maximum Unit

This unit takes two packed operand vectors and writes, lane by lane, the smaller or the larger of each same-index pair of floating-point values. One control input chooses the minimum or maximum function, and one datapath serves both. A size input sets the lane format: single precision gives two 32-bit lanes per 64-bit half, and half precision gives four 16-bit lanes per half. A quad input sets the vector width. When it is low, one 64-bit half is processed. When it is high, two halves are processed, for a 128-bit vector.

The comparison follows IEEE ordering, with signed zeros ordered so that -0.0 lies below +0.0. Any NaN input replaces that lane's result with the default NaN. The floating-point environment is fixed: subnormal inputs are flushed to a zero of the same sign before the compare. A signaling NaN in any active lane raises an invalid-operation flag. The result is registered, and the output strobe follows the input strobe one clock later.

Top module: `fpmm_top`

## Requirements
- R1: `in_half`=0 gives 32-bit lanes at bits [32k+31:32k]. `in_half`=1 gives 16-bit lanes at bits [16k+15:16k]. `in_quad`=0 processes bits [63:0] only. `in_quad`=1 processes bits [127:0].
- R2: With `in_max`=0, each result lane holds the smaller of the same-index lanes of `opa` and `opb`, using IEEE ordering.
- R3: With `in_max`=1, each result lane holds the larger of the same-index pair.
- R4: In minimum mode, +0.0 against -0.0, in either operand order, returns -0.0 (0x80000000 or 0x8000).
- R5: In maximum mode, +0.0 against -0.0, in either order, returns +0.0.
- R6: If either input lane is a NaN, the result lane is the default NaN: 0x7FC00000 for 32-bit lanes and 0x7E00 for 16-bit lanes. This holds whatever the payload of the input NaN.
- R7: A subnormal input (exponent field zero, mantissa nonzero) is treated as a zero of its own sign. If such an input is selected, it is returned as that signed zero.
- R8: `out_invalid` is 1 when any active lane holds a signaling NaN, meaning a NaN whose mantissa MSB is 0. A signaling NaN in the inactive upper half (`in_quad`=0) and a quiet NaN do not raise it.
- R9: With `in_quad`=0, `out_result[127:64]` is zero.
- R10: `out_valid` equals `in_valid` from one clock earlier. `out_result` and `out_invalid` load only when `in_valid` is 1 and otherwise hold their values.
- R11: While reset is applied, `out_valid`, `out_result` and `out_invalid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands present this cycle |
| in_quad | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| in_half | input | 1 | 1 = 16-bit lanes, 0 = 32-bit lanes |
| in_max | input | 1 | 1 = maximum, 0 = minimum |
| opa | input | 128 | Packed operand A |
| opb | input | 128 | Packed operand B |
| out_valid | output | 1 | Result present |
| out_result | output | 128 | Packed result |
| out_invalid | output | 1 | A signaling NaN was seen in an active lane |

## Verification
The bench sweeps every pair from a 16-value set in each lane format and in both modes. Each set holds signed zeros, subnormals, infinities, quiet and signaling NaNs, and the extreme finite values. The operand pairs are rotated so that each lane index meets different values.

Each corner case catches a specific mistake:
- A design that compares the raw bit patterns as integers orders negative values backwards.
- A design that ignores the sign of zero returns +0.0 from a minimum.
- A design that passes a NaN through leaks its payload instead of returning the default NaN.
- A design that skips the subnormal flush returns a nonzero tiny value.
- A design with a careless lane mask either flags signaling NaNs in the unused upper half or leaves that half of the result nonzero.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int HP_EXP = 5;
  localparam int HP_MAN = 10;
  localparam int HALF_BITS = 64;

  typedef enum logic {
    FPMM_MIN = 1'b0,
    FPMM_MAX = 1'b1
  } fpmm_op_e;
endpackage

// File: rtl/fpmm_rst_sync.sv
module fpmm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
  parameter  int EW = 8,
  parameter  int MW = 23,
  localparam int W  = 1 + EW + MW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_max,
  output logic [W-1:0] res,
  output logic         snan
);
  localparam logic [W-1:0] DNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic          a_nan, b_nan, a_sub, b_sub;
  logic [W-1:0]  fa, fb, ka, kb;
  logic          a_below, pick_a;

  always_comb begin
    a_nan = (&a[W-2:MW]) && (|a[MW-1:0]);
    b_nan = (&b[W-2:MW]) && (|b[MW-1:0]);
    a_sub = ~(|a[W-2:MW]) && (|a[MW-1:0]);
    b_sub = ~(|b[W-2:MW]) && (|b[MW-1:0]);
    // flush subnormals to a zero of the same sign
    fa = a_sub ? {a[W-1], {(W-1){1'b0}}} : a;
    fb = b_sub ? {b[W-1], {(W-1){1'b0}}} : b;
    // map sign-magnitude to a monotone unsigned key; -0 sorts just below +0
    ka = fa[W-1] ? ~fa : {1'b1, fa[W-2:0]};
    kb = fb[W-1] ? ~fb : {1'b1, fb[W-2:0]};
    a_below = ka < kb;
    pick_a  = sel_max ? !a_below : a_below;
    if (a_nan || b_nan) res = DNAN;
    else                res = pick_a ? fa : fb;
    snan = (a_nan && !a[MW-1]) || (b_nan && !b[MW-1]);
  end
endmodule

// File: rtl/fpmm_half.sv
module fpmm_half
  import fpmm_pkg::*;
#(
  parameter  int HW    = HALF_BITS,
  localparam int SP_W  = 1 + SP_EXP + SP_MAN,
  localparam int HP_W  = 1 + HP_EXP + HP_MAN,
  localparam int SP_N  = HW / SP_W,
  localparam int HP_N  = HW / HP_W
) (
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  input  logic          sel_half,
  input  logic          sel_max,
  output logic [HW-1:0] res,
  output logic          snan_any
);
  logic [HW-1:0]   res_sp, res_hp;
  logic [SP_N-1:0] sn_sp;
  logic [HP_N-1:0] sn_hp;

  for (genvar g = 0; g < SP_N; g++) begin : g_sp
    fpmm_lane #(.EW(SP_EXP), .MW(SP_MAN)) u_lane (
      .a       (a[g*SP_W +: SP_W]),
      .b       (b[g*SP_W +: SP_W]),
      .sel_max (sel_max),
      .res     (res_sp[g*SP_W +: SP_W]),
      .snan    (sn_sp[g])
    );
  end

  for (genvar g = 0; g < HP_N; g++) begin : g_hp
    fpmm_lane #(.EW(HP_EXP), .MW(HP_MAN)) u_lane (
      .a       (a[g*HP_W +: HP_W]),
      .b       (b[g*HP_W +: HP_W]),
      .sel_max (sel_max),
      .res     (res_hp[g*HP_W +: HP_W]),
      .snan    (sn_hp[g])
    );
  end

  always_comb begin
    res      = sel_half ? res_hp : res_sp;
    snan_any = sel_half ? (|sn_hp) : (|sn_sp);
  end
endmodule

// File: rtl/fpmm_top.sv
module fpmm_top
  import fpmm_pkg::*;
#(
  parameter  int HW     = HALF_BITS,
  parameter  int HALVES = 2,
  localparam int VW     = HW * HALVES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_quad,
  input  logic          in_half,
  input  logic          in_max,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  output logic          out_valid,
  output logic [VW-1:0] out_result,
  output logic          out_invalid
);
  logic              rst_q;
  fpmm_op_e          op_sel;
  logic [VW-1:0]     half_res;
  logic [HALVES-1:0] half_sn;
  logic [VW-1:0]     res_nxt;
  logic              inv_nxt;
  logic              vld_q, inv_q;
  logic [VW-1:0]     res_q;

  fpmm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign op_sel = in_max ? FPMM_MAX : FPMM_MIN;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    fpmm_half #(.HW(HW)) u_half (
      .a        (opa[h*HW +: HW]),
      .b        (opb[h*HW +: HW]),
      .sel_half (in_half),
      .sel_max  (op_sel == FPMM_MAX),
      .res      (half_res[h*HW +: HW]),
      .snan_any (half_sn[h])
    );
  end

  // next-state: mask halves beyond the lowest one when not in quad mode
  always_comb begin
    res_nxt = '0;
    inv_nxt = 1'b0;
    for (int h = 0; h < HALVES; h++) begin
      if (h == 0 || in_quad) begin
        res_nxt[h*HW +: HW] = half_res[h*HW +: HW];
        inv_nxt = inv_nxt | half_sn[h];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_nxt;
        inv_q <= inv_nxt;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_invalid = inv_q;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !in_quad) |=> (out_result[VW-1:HW] == '0));
  assert_min_neg_zero_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !in_half && !in_max && opa[31:0] == 32'h0 && opb[31:0] == 32'h8000_0000)
      |=> (out_result[31:0] == 32'h8000_0000));
  assert_dnan_sp_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !in_half && (&opa[30:23]) && (|opa[22:0]))
      |=> (out_result[31:0] == 32'h7FC0_0000));
endmodule

// File: tb/tb_fpmm_top.sv
module tb_fpmm_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_quad, in_half, in_max;
  logic [127:0] opa, opb;
  logic         out_valid, out_invalid;
  logic [127:0] out_result;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmm_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_quad(in_quad),
    .in_half(in_half), .in_max(in_max), .opa(opa), .opb(opb),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid)
  );

  function automatic logic [31:0] v32(input int i);
    case (i % 16)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'h0000_0001;
      6: return 32'h8000_0001;  7: return 32'h7F80_0000;
      8: return 32'hFF80_0000;  9: return 32'h7FC0_0001;
      10: return 32'h7F80_0001; 11: return 32'h7F7F_FFFF;
      12: return 32'h0080_0000; 13: return 32'h8080_0000;
      14: return 32'h3EAA_AAAB; default: return 32'hC049_0FDB;
    endcase
  endfunction

  function automatic logic [31:0] v16(input int i);
    case (i % 16)
      0: return 32'h0000;  1: return 32'h8000;  2: return 32'h3C00;
      3: return 32'hBC00;  4: return 32'h4000;  5: return 32'h0001;
      6: return 32'h8001;  7: return 32'h7C00;  8: return 32'hFC00;
      9: return 32'h7E01;  10: return 32'h7C01; 11: return 32'h7BFF;
      12: return 32'h0400; 13: return 32'h8400; 14: return 32'h3555;
      default: return 32'hC555;
    endcase
  endfunction

  // reference lane: sign/magnitude compare, written from the requirements
  function automatic void ref_lane(input logic [31:0] ai, input logic [31:0] bi,
                                   input bit h, input bit mx,
                                   output logic [31:0] r, output bit sn);
    int w, mw;
    logic [31:0] mm, em, sm, qb, a, b, ma, mb;
    bit an, bn, a_less;
    w  = h ? 16 : 32;
    mw = h ? 10 : 23;
    mm = (32'h1 << mw) - 32'h1;
    sm = 32'h1 << (w - 1);
    em = (sm - 32'h1) & ~mm;
    qb = 32'h1 << (mw - 1);
    a = ai; b = bi;
    an = ((a & em) == em) && ((a & mm) != 0);
    bn = ((b & em) == em) && ((b & mm) != 0);
    sn = (an && ((a & qb) == 0)) || (bn && ((b & qb) == 0));
    if (((a & em) == 0) && ((a & mm) != 0)) a = a & sm;
    if (((b & em) == 0) && ((b & mm) != 0)) b = b & sm;
    if (an || bn) begin
      r = em | qb;
    end else begin
      ma = a & ~sm; mb = b & ~sm;
      if (ma == 0 && mb == 0)               a_less = ((a & sm) != 0) && ((b & sm) == 0);
      else if ((a & sm) != (b & sm))        a_less = (a & sm) != 0;
      else if ((a & sm) == 0)               a_less = ma < mb;
      else                                  a_less = ma > mb;
      r = mx ? (a_less ? b : a) : (a_less ? a : b);
    end
  endfunction

  function automatic void ref_vec(input logic [127:0] a, input logic [127:0] b,
                                  input bit q, input bit h, input bit mx,
                                  output logic [127:0] r, output bit inv);
    int w;
    logic [127:0] msk;
    logic [31:0] lr;
    bit ls;
    w = h ? 16 : 32;
    msk = h ? 128'hFFFF : 128'hFFFF_FFFF;
    r = '0; inv = 0;
    for (int k = 0; k < 128 / w; k++) begin
      if (q || (k * w < 64)) begin
        ref_lane(32'((a >> (k*w)) & msk), 32'((b >> (k*w)) & msk), h, mx, lr, ls);
        r = r | ({96'b0, lr} << (k*w));
        inv = inv | ls;
      end
    end
  endfunction

  task automatic check(input string tag, input logic [127:0] er, input bit ei, input bit ev);
    checks++;
    if (out_result !== er || out_invalid !== ei || out_valid !== ev) begin
      errs++;
      $display("FAIL %s: got res=%h inv=%b vld=%b expected res=%h inv=%b vld=%b",
               tag, out_result, out_invalid, out_valid, er, ei, ev);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                     input bit q, input bit h, input bit mx);
    logic [127:0] er;
    bit ei;
    ref_vec(a, b, q, h, mx, er, ei);
    @(negedge clk);
    opa = a; opb = b; in_quad = q; in_half = h; in_max = mx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, er, ei, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, held;
    rst_n = 1'b0; in_valid = 1'b0; in_quad = 1'b0; in_half = 1'b0; in_max = 1'b0;
    opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check("R11 reset state", 128'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 idle after release", 128'h0, 1'b0, 1'b0);

    // R1 lane placement, 32-bit quad
    run("R1 sp quad layout",
        {32'h4000_0000, 32'hBF80_0000, 32'h3F80_0000, 32'hC000_0000},
        {32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 32'hC080_0000}, 1, 0, 0);
    check("R1 sp quad layout value",
          {32'h3F80_0000, 32'hBF80_0000, 32'h3F80_0000, 32'hC080_0000}, 1'b0, 1'b1);
    // R4 / R5 signed zeros, both orders
    run("R4 min +0,-0 sp", 128'h0, {96'h0, 32'h8000_0000}, 0, 0, 0);
    check("R4 min +0,-0 value", {96'h0, 32'h8000_0000}, 1'b0, 1'b1);
    run("R4 min -0,+0 hp", {112'h0, 16'h8000}, 128'h0, 0, 1, 0);
    check("R4 min -0,+0 value", {64'h0, 48'h0, 16'h8000}, 1'b0, 1'b1);
    run("R5 max -0,+0 sp", {96'h0, 32'h8000_0000}, 128'h0, 0, 0, 1);
    check("R5 max value", 128'h0, 1'b0, 1'b1);
    // R6 NaN payload discarded
    run("R6 hp nan", {112'h0, 16'hFE55}, {112'h0, 16'h3C00}, 0, 1, 1);
    check("R6 hp default nan", {112'h0, 16'h7E00}, 1'b0, 1'b1);
    // R7 subnormal flush
    run("R7 hp subnormal min", {112'h0, 16'h0001}, {112'h0, 16'h8001}, 0, 1, 0);
    check("R7 flushed -0", {112'h0, 16'h8000}, 1'b0, 1'b1);
    run("R7 hp subnormal max", {112'h0, 16'h0003}, {112'h0, 16'h8000}, 0, 1, 1);
    check("R7 flushed +0", 128'h0, 1'b0, 1'b1);
    // R8 / R9 inactive upper half
    a = {32'h7F80_0001, 32'h1234_5678, 32'h3F80_0000, 32'h0};
    run("R8_R9 sp upper snan inactive", a, a, 0, 0, 0);
    check("R9 upper zero", {64'h0, 32'h3F80_0000, 32'h0}, 1'b0, 1'b1);
    run("R8 sp upper snan active", a, a, 1, 0, 0);
    check("R8 flag set", {32'h7FC0_0000, 32'h1234_5678, 32'h3F80_0000, 32'h0}, 1'b1, 1'b1);
    run("R8 qnan no flag", {96'h0, 32'h7FC0_0000}, 128'h0, 0, 0, 0);
    // R10 hold while idle
    held = out_result;
    @(negedge clk);
    check("R10 held, valid low", held, 1'b0, 1'b0);

    // sweeps: R2 min, R3 max, R1 lanes, R6, R7, R8 across patterns
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int m = 0; m < 2; m++) begin
          a = '0; b = '0;
          for (int k = 0; k < 4; k++) begin
            a[k*32 +: 32] = v32(i + k);
            b[k*32 +: 32] = v32(j + 5*k);
          end
          run(m ? "R3 sp sweep max" : "R2 sp sweep min", a, b, ((i + j) % 2) == 0, 0, m[0]);
          for (int k = 0; k < 8; k++) begin
            a[k*16 +: 16] = v16(i + k)[15:0];
            b[k*16 +: 16] = v16(j + 3*k)[15:0];
          end
          run(m ? "R3 hp sweep max" : "R2 hp sweep min", a, b, ((i + j) % 3) != 0, 1, m[0]);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule